// File: doc/BRIEF.md
# Keyed Flash Program/Erase Controller

This block sits between a processor bus and a flash array. It keeps a small register file with four registers: control, key, address and data. Software must first set a write-enable bit. It then writes three fixed values to the key register in a set order, and only then may it set the start bit. A start that passes this gate sends one request (a word program or a page erase) to the array over a req/ack handshake. The start bit reads as busy until the array answers.

The array reports two error flags with its acknowledge. The block captures them into sticky status bits. Only a completed no-op operation clears these bits, and that no-op must pass through the same unlock gate. Each register can be written in three ways, selected by the low bits of the register select: a raw write replaces the value, a set write ORs bits in, and a clear write removes bits. This lets software change single bits without a read-modify-write.

Top module: `nvm_keyed_ctrl`

## Requirements
- R1: After reset, every register reads zero and `arr_req` is low.
- R2: `bus_sel[3:2]` selects the register: 0 control, 1 key, 2 address, 3 data. `bus_sel[1:0]` selects the write form: 0 raw, 1 set (OR), 2 clear (AND-NOT), 3 no effect. Reads return the stored value whatever the form is. The key register reads as zero. The control layout is: operation code in bits [3:0], low-voltage error in bit 12, write error in bit 13, write enable in bit 14, start/busy in bit 15.
- R3: The key FSM opens only after three key writes, in order 0x00000000, 0xAA996655, 0x556699AA. Any other value sends it back to the start. A zero write always counts as the first step of a new sequence.
- R4: Key writes made while write enable is 0 do not count. A start with write enable at 0 or without a full sequence is ignored: bit 15 stays 0 and no request is raised.
- R5: An accepted start with code 1 (word write) or code 4 (page erase) raises `arr_req` on the next cycle, carrying the code, the address and the data. `arr_req` stays high until `arr_ack` is sampled. Bit 15 reads 1 from the start until that same edge.
- R6: An open unlock serves one start only. It is lost on any control write that sets bit 15, and also when write enable is 0.
- R7: An accepted start with code 0 (no-op) raises no request. Bit 15 reads 1 for exactly one cycle, and both error bits are cleared.
- R8: On acknowledge, `arr_wrerr` and `arr_lvderr` are ORed into bits 13 and 12. These bits stay set through later program and erase operations.
- R9: While bit 15 is 1, writes to the operation code, the address and the data have no effect. Software writes never change bits 12, 13 or 15 directly.
- R10: Set and clear writes change only the bits that are 1 in the written word, and form 3 changes nothing.
- R11: An accepted start with any other code raises no request. Bit 15 reads 1 for one cycle, and the error bits are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 4 | Register (bits 3:2) and write form (bits 1:0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| arr_req | output | 1 | Operation request to the array |
| arr_op | output | OP_W | Operation code of the request |
| arr_addr | output | ADDR_W | Target address |
| arr_wdata | output | 32 | Word to program |
| arr_ack | input | 1 | Array completion |
| arr_wrerr | input | 1 | Write error, valid with ack |
| arr_lvderr | input | 1 | Low-voltage error, valid with ack |

## Verification
The hardest state to reach from the ports is a register write that lands while an operation is in flight. The bench reaches it by holding off the array acknowledge for several cycles. During that window it tries raw writes to the address and to the control register, and checks that neither the address nor the busy bit changes.

Other cases also need a precise order of writes. These include a broken key sequence, a sequence restarted by a repeated zero, a sequence written before write enable was set, and an unlock lost by clearing write enable. The bench covers these by ordering the writes exactly. Sticky errors are checked by following a failed erase with a clean write, an unknown code and a no-op. A behavioural model checks every cycle alongside these directed checks.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_KEY  = 2'd1,
      REG_ADDR = 2'd2,
      REG_DATA = 2'd3
   } reg_e;

   typedef enum logic [1:0] {
      FORM_RAW  = 2'd0,
      FORM_SET  = 2'd1,
      FORM_CLR  = 2'd2,
      FORM_NONE = 2'd3
   } form_e;

   localparam int CB_LVD  = 12;
   localparam int CB_WERR = 13;
   localparam int CB_WEN  = 14;
   localparam int CB_GO   = 15;

   function automatic logic [BUS_W-1:0] apply_form(form_e f,
                                                   logic [BUS_W-1:0] cur,
                                                   logic [BUS_W-1:0] w);
      case (f)
         FORM_RAW: apply_form = w;
         FORM_SET: apply_form = cur | w;
         FORM_CLR: apply_form = cur & ~w;
         default:  apply_form = cur;
      endcase
   endfunction
endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm #(
   parameter logic [31:0] KEY_A = 32'h0000_0000,
   parameter logic [31:0] KEY_B = 32'hAA99_6655,
   parameter logic [31:0] KEY_C = 32'h5566_99AA
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wen,
   input  logic        key_wr,
   input  logic [31:0] key_val,
   input  logic        consume,
   output logic        unlocked
);
   typedef enum logic [1:0] {K_IDLE, K_SEEN_A, K_SEEN_B, K_OPEN} kst_e;
   kst_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!wen || consume) begin
         st_d = K_IDLE;
      end else if (key_wr) begin
         if (key_val == KEY_A)                              st_d = K_SEEN_A;
         else if (st_q == K_SEEN_A && key_val == KEY_B)     st_d = K_SEEN_B;
         else if (st_q == K_SEEN_B && key_val == KEY_C)     st_d = K_OPEN;
         else                                               st_d = K_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= K_IDLE;
      else        st_q <= st_d;
   end

   assign unlocked = (st_q == K_OPEN);

   // R3: opening only follows a key write made in the second step
   a_r3_open_after_seq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> ($past(st_q == K_SEEN_B) && $past(key_wr)));
   // R6: write enable low closes the unlock
   a_r6_wen_closes: assert property (@(posedge clk) disable iff (!rst_n)
      !wen |=> !unlocked);
   // R6: a consuming control write closes the unlock
   a_r6_single_use: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> !unlocked);
endmodule

// File: rtl/nvm_op_launch.sv
module nvm_op_launch #(
   parameter int OP_W     = 4,
   parameter int OP_NOP   = 0,
   parameter int OP_WRITE = 1,
   parameter int OP_ERASE = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [OP_W-1:0] op,
   input  logic            ack,
   input  logic            ack_werr,
   input  logic            ack_lerr,
   output logic            busy,
   output logic            req,
   output logic            werr,
   output logic            lerr
);
   localparam logic [OP_W-1:0] C_NOP   = OP_W'(OP_NOP);
   localparam logic [OP_W-1:0] C_WRITE = OP_W'(OP_WRITE);
   localparam logic [OP_W-1:0] C_ERASE = OP_W'(OP_ERASE);

   logic is_nop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         req      <= 1'b0;
         werr     <= 1'b0;
         lerr     <= 1'b0;
         is_nop_q <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            req      <= (op == C_WRITE) || (op == C_ERASE);
            is_nop_q <= (op == C_NOP);
         end
      end else if (req) begin
         if (ack) begin
            busy <= 1'b0;
            req  <= 1'b0;
            werr <= werr | ack_werr;
            lerr <= lerr | ack_lerr;
         end
      end else begin
         busy <= 1'b0;
         if (is_nop_q) begin
            werr <= 1'b0;
            lerr <= 1'b0;
         end
      end
   end

   // R5: a request only exists inside a busy window
   a_r5_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> busy);
   // R5: request held until acknowledged
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req);
   // R7: an operation without request finishes after one cycle
   a_r7_short_op: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !req) |=> !busy);
   // R8: error bits fall only at a no-op completion
   a_r8_sticky_werr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(werr) |-> $past(busy && !req && is_nop_q));
   a_r8_sticky_lerr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lerr) |-> $past(busy && !req && is_nop_q));
endmodule

// File: rtl/nvm_keyed_ctrl.sv
module nvm_keyed_ctrl #(
   parameter int          ADDR_W   = 32,
   parameter int          OP_W     = 4,
   parameter int          OP_NOP   = 0,
   parameter int          OP_WRITE = 1,
   parameter int          OP_ERASE = 4,
   parameter logic [31:0] KEY_A    = 32'h0000_0000,
   parameter logic [31:0] KEY_B    = 32'hAA99_6655,
   parameter logic [31:0] KEY_C    = 32'h5566_99AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_sel,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              arr_req,
   output logic [OP_W-1:0]   arr_op,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [31:0]       arr_wdata,
   input  logic              arr_ack,
   input  logic              arr_wrerr,
   input  logic              arr_lvderr
);
   import nvm_ctrl_pkg::*;

   localparam int N_REGS = 4;

   if (ADDR_W < 1 || ADDR_W > BUS_W) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..32");
   end
   if (OP_W < 3 || OP_W > CB_LVD) begin : g_bad_op_w
      $error("OP_W must lie in 3..12");
   end

   logic [OP_W-1:0]   op_q;
   logic              wen_q;
   logic [31:0]       key_q;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       data_q;
   logic              busy, werr, lerr, unlocked;

   form_e form;
   assign form = form_e'(bus_sel[1:0]);

   logic [N_REGS-1:0] hit;
   for (genvar g = 0; g < N_REGS; g++) begin : g_hit
      assign hit[g] = bus_wr && (bus_sel[3:2] == g[1:0]) && (form != FORM_NONE);
   end

   logic [31:0] ctrl_cur, addr_cur, ctrl_new, key_new, addr_new, data_new;
   always_comb begin
      ctrl_cur              = '0;
      ctrl_cur[OP_W-1:0]    = op_q;
      ctrl_cur[CB_LVD]      = lerr;
      ctrl_cur[CB_WERR]     = werr;
      ctrl_cur[CB_WEN]      = wen_q;
      ctrl_cur[CB_GO]       = busy;
      addr_cur              = '0;
      addr_cur[ADDR_W-1:0]  = addr_q;
      ctrl_new = apply_form(form, ctrl_cur, bus_wdata);
      key_new  = apply_form(form, key_q,    bus_wdata);
      addr_new = apply_form(form, addr_cur, bus_wdata);
      data_new = apply_form(form, data_q,   bus_wdata);
   end

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = &{1'b0, ctrl_new[31:16], ctrl_new[CB_WERR],
                               ctrl_new[CB_LVD], ctrl_new[CB_LVD-1:OP_W],
                               addr_new};

   logic go_wr, start;
   assign go_wr = hit[REG_CTRL] && ctrl_new[CB_GO];
   assign start = go_wr && !busy && unlocked && wen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= '0;
         wen_q  <= 1'b0;
         key_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (hit[REG_CTRL]) begin
            wen_q <= ctrl_new[CB_WEN];
            if (!busy) op_q <= ctrl_new[OP_W-1:0];
         end
         if (hit[REG_KEY]) key_q <= key_new;
         if (hit[REG_ADDR] && !busy) addr_q <= addr_new[ADDR_W-1:0];
         if (hit[REG_DATA] && !busy) data_q <= data_new;
      end
   end

   nvm_key_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (wen_q),
      .key_wr   (hit[REG_KEY]),
      .key_val  (key_new),
      .consume  (go_wr),
      .unlocked (unlocked)
   );

   nvm_op_launch #(.OP_W(OP_W), .OP_NOP(OP_NOP), .OP_WRITE(OP_WRITE),
                   .OP_ERASE(OP_ERASE)) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op       (ctrl_new[OP_W-1:0]),
      .ack      (arr_ack),
      .ack_werr (arr_wrerr),
      .ack_lerr (arr_lvderr),
      .busy     (busy),
      .req      (arr_req),
      .werr     (werr),
      .lerr     (lerr)
   );

   always_comb begin
      case (reg_e'(bus_sel[3:2]))
         REG_CTRL: bus_rdata = ctrl_cur;
         REG_ADDR: bus_rdata = addr_cur;
         REG_DATA: bus_rdata = data_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign arr_op    = op_q;
   assign arr_addr  = addr_q;
   assign arr_wdata = data_q;

   // R4: busy only rises out of an open unlock with write enable set
   a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(unlocked && wen_q));
   // R9: operands frozen while busy
   a_r9_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));
   // R5: request payload stays put while waiting
   a_r5_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && !arr_ack) |=> ($stable(arr_op) && $stable(arr_addr) && $stable(arr_wdata)));
endmodule

// File: tb/sim_nvm_keyed_ctrl.sv
`timescale 1ns/100ps
module sim_nvm_keyed_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_sel = 4'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        arr_req;
   logic [3:0]  arr_op;
   logic [31:0] arr_addr;
   logic [31:0] arr_wdata;
   logic        arr_ack = 1'b0;
   logic        arr_wrerr = 1'b0;
   logic        arr_lvderr = 1'b0;

   always #2.5 clk = ~clk;

   nvm_keyed_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_req(arr_req),
      .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .arr_ack(arr_ack), .arr_wrerr(arr_wrerr), .arr_lvderr(arr_lvderr)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // array responder
   int resp_delay = 0;
   int resp_cnt = 0;
   logic resp_werr = 1'b0, resp_lerr = 1'b0;
   always @(negedge clk) begin
      if (arr_ack) begin
         arr_ack = 1'b0; arr_wrerr = 1'b0; arr_lvderr = 1'b0;
      end else if (arr_req) begin
         if (resp_cnt >= resp_delay) begin
            arr_ack = 1'b1; arr_wrerr = resp_werr; arr_lvderr = resp_lerr;
            resp_cnt = 0;
         end else resp_cnt++;
      end
   end

   // behavioural reference model
   int m_op, m_ks, m_addr, m_data, m_key;
   bit m_go, m_wen, m_werr, m_lerr, m_req;

   function automatic int form_fn(int f, int cur, int w);
      if (f == 0) return w;
      if (f == 1) return cur | w;
      if (f == 2) return cur & ~w;
      return cur;
   endfunction

   function automatic int m_ctrl();
      return (int'(m_go) << 15) | (int'(m_wen) << 14) | (int'(m_werr) << 13)
             | (int'(m_lerr) << 12) | m_op;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_op = 0; m_ks = 0; m_addr = 0; m_data = 0; m_key = 0;
         m_go = 0; m_wen = 0; m_werr = 0; m_lerr = 0; m_req = 0;
      end else begin
         bit o_go, o_wen, n_go, n_req, n_wen, n_werr, n_lerr;
         int n_op, n_ks, n_addr, n_data, n_key, nv, r, f;
         o_go = m_go; o_wen = m_wen;
         n_go = m_go; n_req = m_req; n_wen = m_wen; n_werr = m_werr; n_lerr = m_lerr;
         n_op = m_op; n_ks = m_ks; n_addr = m_addr; n_data = m_data; n_key = m_key;
         if (o_go) begin
            if (m_req) begin
               if (arr_ack) begin
                  n_go = 0; n_req = 0;
                  n_werr = m_werr | arr_wrerr; n_lerr = m_lerr | arr_lvderr;
               end
            end else begin
               n_go = 0;
               if (m_op == 0) begin n_werr = 0; n_lerr = 0; end
            end
         end
         r = int'(bus_sel[3:2]); f = int'(bus_sel[1:0]);
         if (!o_wen) n_ks = 0;
         if (bus_wr && f != 3) begin
            if (r == 0) begin
               nv = form_fn(f, m_ctrl(), int'(bus_wdata));
               n_wen = nv[14];
               if (!o_go) n_op = nv & 15;
               if (nv[15]) begin
                  if (!o_go && m_ks == 3 && o_wen) begin
                     n_go = 1;
                     n_req = (n_op == 1) || (n_op == 4);
                  end
                  n_ks = 0;
               end
            end else if (r == 1) begin
               nv = form_fn(f, m_key, int'(bus_wdata));
               n_key = nv;
               if (o_wen) begin
                  if (nv == 0) n_ks = 1;
                  else if (m_ks == 1 && nv == 32'hAA996655) n_ks = 2;
                  else if (m_ks == 2 && nv == 32'h556699AA) n_ks = 3;
                  else n_ks = 0;
               end
            end else if (r == 2) begin
               if (!o_go) n_addr = form_fn(f, m_addr, int'(bus_wdata));
            end else begin
               if (!o_go) n_data = form_fn(f, m_data, int'(bus_wdata));
            end
         end
         m_go = n_go; m_req = n_req; m_wen = n_wen; m_werr = n_werr; m_lerr = n_lerr;
         m_op = n_op; m_ks = n_ks; m_addr = n_addr; m_data = n_data; m_key = n_key;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         chk("R5 model req", {31'b0, arr_req}, {31'b0, m_req});
         if (arr_req) begin
            chk("R5 model op", {28'b0, arr_op}, m_op);
            chk("R5 model addr", arr_addr, m_addr);
            chk("R5 model data", arr_wdata, m_data);
         end
         if (!bus_wr && bus_sel == 4'd0) chk("R2 model ctrl", bus_rdata, m_ctrl());
      end
   end

   // bus helpers
   task automatic wr(logic [3:0] sel, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel = 4'd0; bus_wdata = '0;
   endtask

   task automatic rd(logic [3:0] sel, output logic [31:0] d);
      @(negedge clk);
      bus_sel = sel;
      #1 d = bus_rdata;
      bus_sel = 4'd0;
   endtask

   task automatic keys();
      wr(4'd4, 32'h0000_0000);
      wr(4'd4, 32'hAA99_6655);
      wr(4'd4, 32'h5566_99AA);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         #1;
         if (bus_rdata[15] == 1'b0) break;
      end
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog got=%0d exp=<20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, v);  chk("R1 ctrl", v, 32'h0);
      rd(4'd8, v);  chk("R1 addr", v, 32'h0);
      rd(4'd12, v); chk("R1 data", v, 32'h0);
      chk("R1 req", {31'b0, arr_req}, 32'h0);

      // R4 start without any key sequence
      wr(4'd0, 32'h0000_4001);
      wr(4'd1, 32'h0000_8000);
      #1 chk("R4 no unlock, go bit", bus_rdata, 32'h0000_4001);
      chk("R4 no unlock, req", {31'b0, arr_req}, 32'h0);

      // R5 word write
      wr(4'd8,  32'h0000_1234);
      wr(4'd12, 32'hCAFE_0001);
      keys();
      wr(4'd1, 32'h0000_8000);
      #1 chk("R5 req raised", {31'b0, arr_req}, 32'h1);
      chk("R5 op", {28'b0, arr_op}, 32'h1);
      chk("R5 addr", arr_addr, 32'h0000_1234);
      chk("R5 data", arr_wdata, 32'hCAFE_0001);
      chk("R5 busy", bus_rdata, 32'h0000_C001);
      wait_idle();
      chk("R5 done", bus_rdata, 32'h0000_4001);

      // R6 single use: start again without keys
      wr(4'd1, 32'h0000_8000);
      #1 chk("R6 reuse ignored", bus_rdata, 32'h0000_4001);

      // R3 broken sequence
      wr(4'd4, 32'h0000_0000);
      wr(4'd4, 32'hAA99_6655);
      wr(4'd4, 32'h1234_5678);
      wr(4'd4, 32'h5566_99AA);
      wr(4'd1, 32'h0000_8000);
      #1 chk("R3 broken seq", bus_rdata, 32'h0000_4001);

      // R3 repeated zero restarts the sequence
      wr(4'd4, 32'h0000_0000);
      keys();
      wr(4'd1, 32'h0000_8000);
      #1 chk("R3 restart accepted", bus_rdata, 32'h0000_C001);
      wait_idle();

      // R6 clearing write enable drops an open unlock
      keys();
      wr(4'd2, 32'h0000_4000);
      wr(4'd1, 32'h0000_4000);
      wr(4'd1, 32'h0000_8000);
      #1 chk("R6 wen clear drops unlock", bus_rdata, 32'h0000_4001);

      // R4 keys written with write enable low
      wr(4'd2, 32'h0000_4000);
      keys();
      wr(4'd1, 32'h0000_4000);
      wr(4'd1, 32'h0000_8000);
      #1 chk("R4 keys before wen", bus_rdata, 32'h0000_4001);
      chk("R4 req low", {31'b0, arr_req}, 32'h0);

      // R8 page erase with write error
      resp_werr = 1'b1;
      wr(4'd0, 32'h0000_4004);
      keys();
      wr(4'd1, 32'h0000_8000);
      #1 chk("R5 erase op", {28'b0, arr_op}, 32'h4);
      wait_idle();
      resp_werr = 1'b0;
      chk("R8 werr latched", bus_rdata, 32'h0000_6004);

      // R8, R9 clean write keeps error; raw write cannot clear it
      wr(4'd0, 32'h0000_4001);
      #1 chk("R9 raw cannot clear werr", bus_rdata, 32'h0000_6001);
      resp_lerr = 1'b1;
      keys();
      wr(4'd1, 32'h0000_8000);
      wait_idle();
      resp_lerr = 1'b0;
      chk("R8 sticky + lvd", bus_rdata, 32'h0000_7001);

      // R11 unsupported code
      wr(4'd0, 32'h0000_4002);
      keys();
      wr(4'd1, 32'h0000_8000);
      #1 chk("R11 busy one cycle", bus_rdata, 32'h0000_F002);
      chk("R11 no req", {31'b0, arr_req}, 32'h0);
      @(negedge clk); #1;
      chk("R11 errors kept", bus_rdata, 32'h0000_7002);

      // R7 no-op clears errors
      wr(4'd0, 32'h0000_4000);
      keys();
      wr(4'd1, 32'h0000_8000);
      #1 chk("R7 busy one cycle", bus_rdata, 32'h0000_F000);
      chk("R7 no req", {31'b0, arr_req}, 32'h0);
      @(negedge clk); #1;
      chk("R7 errors cleared", bus_rdata, 32'h0000_4000);

      // R9 writes ignored while busy
      resp_delay = 6;
      wr(4'd8, 32'h0000_0ABC);
      wr(4'd0, 32'h0000_4001);
      keys();
      wr(4'd1, 32'h0000_8000);
      wr(4'd8, 32'hFFFF_FFFF);
      wr(4'd0, 32'h0000_4004);
      #1 chk("R9 go bit held, op frozen", bus_rdata, 32'h0000_C001);
      chk("R9 req held", {31'b0, arr_req}, 32'h1);
      wait_idle();
      resp_delay = 0;
      rd(4'd8, v); chk("R9 addr frozen", v, 32'h0000_0ABC);

      // R10 write forms
      wr(4'd8, 32'h0000_00F0);
      wr(4'd9, 32'h0000_0F00);
      rd(4'd8, v); chk("R10 set form", v, 32'h0000_0FF0);
      wr(4'd10, 32'h0000_00F0);
      rd(4'd8, v); chk("R10 clear form", v, 32'h0000_0F00);
      wr(4'd11, 32'hFFFF_FFFF);
      rd(4'd8, v); chk("R10 no-effect form", v, 32'h0000_0F00);
      rd(4'd5, v); chk("R2 key reads zero", v, 32'h0);

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule